// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit and receive error counters of a CAN node and turns them into the node's fault confinement state. The protocol engine drives it with one-cycle event strobes: receiver errors of two weights, transmitter errors with qualifiers, successful transfers and a strobe for each sampled recessive bit. Every strobe takes effect at the clock edge that samples it, and the outputs show the result from that edge on.

The block reports both counters as one 16-bit word, a 2-bit state code, a flag that selects passive instead of active error flags, and a driver disable that is high while the node is bus off. Leaving bus off takes 1408 recessive-bit strobes. On that exit both counters are cleared.

Top module: `can_fault_conf`

## Requirements
- R1: After reset `err_cnt_o` is 0, `state_o` is 0 (error active), and `passive_flag_o` and `drv_dis_o` are low.
- R2: A `rx_err_major_i` strobe adds 8 to the receive counter. A `rx_err_minor_i` strobe adds 1. When both come in the same cycle, the counter gains 8. The receive counter is `err_cnt_o[7:0]`.
- R3: While bit 7 of the receive counter is set, receive increment strobes leave the counter unchanged.
- R4: A `tx_err_i` strobe adds 8 to the transmit counter. So does `tx_ack_err_i` when the node is not error passive. The transmit counter is `err_cnt_o[15:8]`.
- R5: A `tx_err_i` strobe that comes with `tx_arb_stuff_i` high adds nothing. A `tx_ack_err_i` strobe in the error passive state adds nothing.
- R6: `rx_ok_i` takes 1 from the receive counter and `tx_ok_i` takes 1 from the transmit counter. A counter already at 0 stays at 0. A decrement is dropped in any cycle where the same counter increments.
- R7: `state_o` is 1 (warning) when either counter is at least 96 and both are below 128. It is 0 (active) when both counters are below 96.
- R8: `state_o` is 2 (error passive) when either counter exceeds 127 and the node is not bus off. `passive_flag_o` is high in states 2 and 3. The node returns to state 1 or 0 as soon as both counters are below 128.
- R9: An increment that takes the transmit counter past 255 puts the node in state 3 (bus off). In bus off, `drv_dis_o` is high, the transmit field reads 255, and all error and ok strobes are ignored.
- R10: In bus off, the 1408th `recessive_i` strobe returns the node to state 0 with both counters at 0. Recessive strobes received outside bus off count toward nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_err_minor_i | input | 1 | Receiver stuff, form, CRC or ACK error |
| rx_err_major_i | input | 1 | Receiver error worth 8 (flag bit error or dominant bit after a flag) |
| rx_ok_i | input | 1 | Valid reception |
| tx_err_i | input | 1 | Transmitter error worth 8 |
| tx_arb_stuff_i | input | 1 | Qualifies tx_err_i as an arbitration stuff error, which is not counted |
| tx_ack_err_i | input | 1 | Transmitter ACK error |
| tx_ok_i | input | 1 | Valid transmission |
| recessive_i | input | 1 | One recessive bit sampled |
| err_cnt_o | output | 16 | Transmit counter in [15:8], receive counter in [7:0] |
| state_o | output | 2 | 0 active, 1 warning, 2 passive, 3 bus off |
| passive_flag_o | output | 1 | Send passive error flags |
| drv_dis_o | output | 1 | Bus output driver disabled |

## Verification
The bench walks the counters across each threshold one step at a time: 95 to 96, 127 to 128, and 254 to 262. An off-by-one compare shows up as the wrong state code at one of these steps. It drives the receive counter past 127 and then sends more increments. A design without the bit 7 hold would move the counter and wrap it later.

It sends ACK errors both in the passive state and just below it, and an arbitration-qualified transmit error. A design that ignored these exceptions would reach bus off on missing acknowledgments.

The bench sends recessive strobes before bus off and checks that 1407 strobes in bus off are not enough. A recovery counter that ran outside bus off, or stopped one count off, would fail that check. A design that kept stale counter values after recovery would show them in `err_cnt_o`.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARNING = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
  parameter int W          = 8,
  parameter int SMALL_STEP = 1,
  parameter int BIG_STEP   = 8,
  parameter bit HOLD_MSB   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_small_i,
  input  logic         inc_big_i,
  input  logic         dec_i,
  input  logic         freeze_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W:0] MAX_V = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   step, sum;
  logic         inc_any, hold;

  generate
    if (HOLD_MSB) begin : g_hold
      assign hold = cnt_q[W-1];
    end else begin : g_nohold
      assign hold = 1'b0;
    end
  endgenerate

  always_comb begin
    inc_any = inc_small_i | inc_big_i;
    step    = inc_big_i ? (W+1)'(BIG_STEP) : (inc_small_i ? (W+1)'(SMALL_STEP) : '0);
    sum     = {1'b0, cnt_q} + step;
    cnt_d   = cnt_q;
    if (clear_i)                       cnt_d = '0;
    else if (freeze_i)                 cnt_d = cnt_q;
    else if (inc_any) begin
      if (!hold) cnt_d = (sum > MAX_V) ? MAX_V[W-1:0] : sum[W-1:0];
    end
    else if (dec_i && cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_dec_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_i && !inc_any && !clear_i) |=> cnt_q == '0);

  generate
    if (HOLD_MSB) begin : g_hold_chk
      p_hold_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q[W-1] && inc_any && !clear_i) |=> cnt_q == $past(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/fc_state.sv
module fc_state
  import can_fc_pkg::*;
#(
  parameter int REC_W    = 8,
  parameter int TEC_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int TEC_MAX  = 255
) (
  input  logic [REC_W-1:0] rec_i,
  input  logic [TEC_W-1:0] tec_i,
  output fc_state_e        state_o
);
  logic bus_off, passive, warn;

  always_comb begin
    bus_off = 32'(tec_i) > TEC_MAX;
    passive = 32'(tec_i) >= PASS_LIM || 32'(rec_i) >= PASS_LIM;
    warn    = 32'(tec_i) >= WARN_LIM || 32'(rec_i) >= WARN_LIM;
    if (bus_off)      state_o = FC_BUSOFF;
    else if (passive) state_o = FC_PASSIVE;
    else if (warn)    state_o = FC_WARNING;
    else              state_o = FC_ACTIVE;
  end
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
  parameter int N_BITS = 1408
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_off_i,
  input  logic recessive_i,
  output logic done_o
);
  localparam int CW = $clog2(N_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!bus_off_i || done_o)   cnt_q <= '0;
    else if (recessive_i)            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = bus_off_i && recessive_i && (cnt_q == CW'(N_BITS - 1));

  p_idle_outside_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_off_i |=> cnt_q == '0);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ERR_STEP  = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 128,
  parameter int RECOV_BITS = 1408
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_err_minor_i,
  input  logic               rx_err_major_i,
  input  logic               rx_ok_i,
  input  logic               tx_err_i,
  input  logic               tx_arb_stuff_i,
  input  logic               tx_ack_err_i,
  input  logic               tx_ok_i,
  input  logic               recessive_i,
  output logic [2*CNT_W-1:0] err_cnt_o,
  output logic [1:0]         state_o,
  output logic               passive_flag_o,
  output logic               drv_dis_o
);
  localparam int TEC_W   = CNT_W + 1;
  localparam int TEC_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] rec;
  logic [TEC_W-1:0] tec;
  logic [CNT_W-1:0] tec_rd;
  fc_state_e        state;
  logic             bus_off, passive, recov_done, tx_inc;

  assign bus_off = (state == FC_BUSOFF);
  assign passive = (state == FC_PASSIVE);
  // arbitration stuff errors and passive ACK errors never reach the counter
  assign tx_inc  = (tx_err_i && !tx_arb_stuff_i) || (tx_ack_err_i && !passive);

  fc_err_counter #(.W(CNT_W), .SMALL_STEP(1), .BIG_STEP(ERR_STEP), .HOLD_MSB(1'b1)) u_rec (
    .clk_i, .rst_ni,
    .inc_small_i(rx_err_minor_i), .inc_big_i(rx_err_major_i), .dec_i(rx_ok_i),
    .freeze_i(bus_off), .clear_i(recov_done), .cnt_o(rec)
  );

  fc_err_counter #(.W(TEC_W), .SMALL_STEP(ERR_STEP), .BIG_STEP(ERR_STEP), .HOLD_MSB(1'b0)) u_tec (
    .clk_i, .rst_ni,
    .inc_small_i(1'b0), .inc_big_i(tx_inc), .dec_i(tx_ok_i),
    .freeze_i(bus_off), .clear_i(recov_done), .cnt_o(tec)
  );

  fc_state #(.REC_W(CNT_W), .TEC_W(TEC_W), .WARN_LIM(WARN_LIM),
             .PASS_LIM(PASS_LIM), .TEC_MAX(TEC_MAX)) u_state (
    .rec_i(rec), .tec_i(tec), .state_o(state)
  );

  fc_recovery #(.N_BITS(RECOV_BITS)) u_recov (
    .clk_i, .rst_ni, .bus_off_i(bus_off), .recessive_i, .done_o(recov_done)
  );

  assign tec_rd         = (32'(tec) > TEC_MAX) ? CNT_W'(TEC_MAX) : tec[CNT_W-1:0];
  assign err_cnt_o      = {tec_rd, rec};
  assign state_o        = state;
  assign passive_flag_o = passive || bus_off;
  assign drv_dis_o      = bus_off;

  p_busoff_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_off && 32'(tec) > TEC_MAX - ERR_STEP && tx_inc) |=> state_o == FC_BUSOFF);

  p_recov_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_dis_o) |-> err_cnt_o == '0);

  p_ack_passive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (passive && tx_ack_err_i && !tx_err_i && !tx_ok_i) |=> tec == $past(tec));

  p_busoff_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off && !recov_done) |=> err_cnt_o == $past(err_cnt_o));
endmodule

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = '0;
  logic [15:0] err_cnt;
  logic [1:0]  state;
  logic        pflag, drv_dis;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] E_RXMIN = 8'h01, E_RXMAJ = 8'h02, E_RXOK = 8'h04, E_TXERR = 8'h08,
                         E_ARB = 8'h10, E_ACK = 8'h20, E_TXOK = 8'h40, E_REC = 8'h80;

  always #2 clk = ~clk;

  can_fault_conf u_can_fault_conf (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_err_minor_i(ev[0]), .rx_err_major_i(ev[1]), .rx_ok_i(ev[2]),
    .tx_err_i(ev[3]), .tx_arb_stuff_i(ev[4]), .tx_ack_err_i(ev[5]),
    .tx_ok_i(ev[6]), .recessive_i(ev[7]),
    .err_cnt_o(err_cnt), .state_o(state), .passive_flag_o(pflag), .drv_dis_o(drv_dis)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ev = e;
    end
    @(negedge clk) ev = '0;
  endtask

  task automatic expect_all(input string tag, input int tec, input int rec, input int st,
                            input int pf, input int dd);
    chk({tag, " cnt"}, err_cnt, (tec << 8) | rec);
    chk({tag, " state"}, state, st);
    chk({tag, " flag"}, pflag, pf);
    chk({tag, " drv"}, drv_dis, dd);
  endtask

  task automatic t_reset;
    expect_all("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_rx_inc;
    pulse(E_RXMIN, 3);            chk("R2 minor x3", err_cnt, 3);
    pulse(E_RXMAJ, 1);            chk("R2 major", err_cnt, 11);
    pulse(E_RXMIN | E_RXMAJ, 1);  chk("R2 both", err_cnt, 19);
    pulse(E_RXOK, 1);             chk("R6 rx ok", err_cnt, 18);
  endtask

  task automatic t_dec;
    pulse(E_RXOK, 18);            chk("R6 rx to zero", err_cnt, 0);
    pulse(E_RXOK, 1);             chk("R6 rx floor", err_cnt, 0);
    pulse(E_TXOK, 1);             chk("R6 tx floor", err_cnt, 0);
    pulse(E_RXMIN | E_RXOK, 1);   chk("R6 inc wins", err_cnt, 1);
    pulse(E_RXOK, 1);             chk("R6 back", err_cnt, 0);
  endtask

  task automatic t_warn;
    pulse(E_RXMAJ, 11);  expect_all("R7 rec 88", 0, 88, 0, 0, 0);
    pulse(E_RXMAJ, 1);   expect_all("R7 rec 96", 0, 96, 1, 0, 0);
    pulse(E_RXOK, 1);    expect_all("R7 rec 95", 0, 95, 0, 0, 0);
  endtask

  task automatic t_passive;
    pulse(E_RXMAJ, 4);   expect_all("R8 rec 127", 0, 127, 1, 0, 0);
    pulse(E_RXMAJ, 1);   expect_all("R8 rec 135", 0, 135, 2, 1, 0);
    pulse(E_RXMAJ, 1);   chk("R3 hold major", err_cnt, 135);
    pulse(E_RXMIN, 2);   chk("R3 hold minor", err_cnt, 135);
    pulse(E_RXOK, 8);    expect_all("R8 exit", 0, 127, 1, 0, 0);
    pulse(E_RXOK, 127);  expect_all("R7 rec clear", 0, 0, 0, 0, 0);
  endtask

  task automatic t_tx;
    pulse(E_TXERR, 11);         expect_all("R4 tec 88", 88, 0, 0, 0, 0);
    pulse(E_TXERR, 1);          expect_all("R7 tec 96", 96, 0, 1, 0, 0);
    pulse(E_TXERR | E_ARB, 1);  chk("R5 arb stuff", err_cnt, 96 << 8);
    pulse(E_TXERR, 4);          expect_all("R8 tec 128", 128, 0, 2, 1, 0);
    pulse(E_ACK, 1);            chk("R5 ack passive", err_cnt, 128 << 8);
    pulse(E_REC, 100);          chk("R10 rec outside", err_cnt, 128 << 8);
    pulse(E_TXOK, 1);           expect_all("R8 tec 127", 127, 0, 1, 0, 0);
    pulse(E_ACK, 1);            expect_all("R4 ack active", 135, 0, 2, 1, 0);
    pulse(E_TXOK, 1);           chk("R6 tx ok", err_cnt, 134 << 8);
  endtask

  task automatic t_busoff;
    pulse(E_RXMIN, 5);    chk("R2 rec 5", err_cnt, (134 << 8) | 5);
    pulse(E_TXERR, 15);   expect_all("R9 tec 254", 254, 5, 2, 1, 0);
    pulse(E_TXERR, 1);    expect_all("R9 bus off", 255, 5, 3, 1, 1);
    pulse(E_RXMIN, 1);    chk("R9 ignore rx err", err_cnt, (255 << 8) | 5);
    pulse(E_RXOK | E_TXOK, 3); chk("R9 ignore ok", err_cnt, (255 << 8) | 5);
    chk("R9 still off", state, 3);
  endtask

  task automatic t_recovery;
    pulse(E_REC, 1407);   expect_all("R10 1407", 255, 5, 3, 1, 1);
    pulse(E_REC, 1);      expect_all("R10 recovered", 0, 0, 0, 0, 0);
    pulse(E_REC, 5);      chk("R10 active rec", err_cnt, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_inc();
        t_dec();
        t_warn();
        t_passive();
        t_tx();
        t_busoff();
        t_recovery();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule